// File: doc/BRIEF.md
# Parallel Display Bus Write Master

This block turns single bytes from a system-side valid/ready stream into write cycles on an 8-bit parallel bus of the strobed kind: active-low chip select, active-low write strobe, active-low read strobe, a command/data select line and the data bus. A display controller on that bus takes the byte on the rising edge of the write strobe. It routes the byte to its command register when the select line is low and to display memory when it is high.

The bus has its own minimum times. These are the strobe low time, the strobe high time, the full cycle time, the setup of select and data ahead of the strobe edge, and the data and chip-select hold after it. All of them are given in nanoseconds and turned into clock counts from a clock-period parameter, with a floor of one cycle. The read strobe never leaves its inactive level. A one-cycle done pulse marks the end of each write, and the block takes no new byte until the cycle-time minimum has passed.

Top module: `pbus_write_master`

## Requirements
- R1: While reset is low at a clock edge, and in the cycle that follows, chip select, write strobe and read strobe are high, done is low and ready is high.
- R2: A byte is taken on a clock edge where valid and ready are both high. Ready then stays low for exactly BUSY cycles, where BUSY = max(CYC-1, HI+L-1, S+L+H). Every byte taken appears on the bus exactly once, in the order it was taken.
- R3: The write strobe stays low for exactly L cycles, where L = max(ceil(60/P), ceil(40/P)) and P is the clock period in ns.
- R4: Chip select falls on the acceptance edge, together with the new select and data values. The write strobe falls exactly S = max(ceil(10/P),1) cycles later.
- R5: The write strobe is low only while chip select is low. Chip select rises exactly H = max(ceil(7/P), ceil(20/P)) cycles after the strobe rises.
- R6: Successive falling edges of the write strobe are at least CYC = ceil(300/P) cycles apart. Between writes the strobe stays high for at least HI = ceil(60/P) cycles.
- R7: Done is high for exactly one cycle per write, in the cycle in which chip select has just risen, and is low at all other times.
- R8: The read strobe is high at all times.
- R9: At the strobe's rising edge the select line equals the taken flag (0 = command, 1 = display data) and the data bus equals the taken byte.
- R10: Changes to valid, the flag or the byte while ready is low do not alter the bus values of the write in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | Block can take a byte |
| in_dc | input | 1 | 0 = command byte, 1 = display data byte |
| in_data | input | DATA_W | Byte to write |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, held high |
| bus_dc | output | 1 | Command/data select |
| bus_data | output | DATA_W | Data bus |
| done | output | 1 | One-cycle pulse when a write has ended |

## Verification
The assertions watch on every cycle that the strobe is low only under chip select, that the strobe low width and the spacing between falling edges meet their counts, that ready stays low while chip select is low, that done pulses only as chip select rises, and that the bus holds still during a select window. Only the bench scenarios can show that the exact setup and hold counts appear, that the busy length is right, that bytes come out in order with the right select level, and that stimulus changed during a busy window leaves the write alone. These scenarios are back-to-back streams, idle gaps, mixed command and data bytes, and extreme byte values.

// File: rtl/pbus_write_pkg.sv
// Package pbus_write_pkg
// Shared phase encoding and the arithmetic that turns a nanosecond minimum
// into a whole number of clock cycles.
// Assumes all times and the clock period are positive integers in ns.
package pbus_write_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_RECOV  = 3'd4
    } phase_t;

    // Ceiling division with a floor of one cycle.
    function automatic int ns_to_cycles(input int t_ns, input int period_ns);
        int c;
        c = (t_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pbus_hold_reg.sv
// Module pbus_hold_reg
// Holds the command/data flag and the byte offered to the bus. Loads on
// acceptance only and keeps both values until the next acceptance, so the
// bus sees no change during a write and for as long as the bus is idle.
// Assumes load is high only for one cycle per accepted byte.
module pbus_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              dc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              dc_q,
    output logic [DATA_W-1:0] data_q
);

    // Capture flag and byte on acceptance; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dc_q   <= 1'b0;
            data_q <= '0;
        end else if (load) begin
            dc_q   <= dc_in;
            data_q <= data_in;
        end
    end

endmodule

// File: rtl/pbus_phase_seq.sv
// Module pbus_phase_seq
// Phase sequencer for one bus write: setup (select low, strobe high),
// strobe low, hold (strobe high, select low), then recovery until the
// cycle-time minimum allows the next byte. All outputs are registered.
// Assumes every phase length is at least one cycle, except REC_C which may be 0.
module pbus_phase_seq
    import pbus_write_pkg::*;
#(
    parameter int SETUP_C = 2,
    parameter int LOW_C   = 12,
    parameter int HOLD_C  = 4,
    parameter int REC_C   = 41,
    parameter int CYC_C   = 60,
    parameter int CNT_W   = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    output logic load,
    output logic cs_n,
    output logic wr_n,
    output logic done
);

    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_C - 1);
    localparam logic [CNT_W-1:0] LOW_LD   = CNT_W'(LOW_C - 1);
    localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_C - 1);
    localparam logic [CNT_W-1:0] REC_LD   = CNT_W'((REC_C > 0) ? REC_C - 1 : 0);
    localparam int               GAP_W    = $clog2(CYC_C + 1);
    localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(CYC_C);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic             last;

    // Ready only between writes; a byte is taken when both sides agree.
    assign in_ready = (phase == PH_IDLE);
    assign load     = in_valid && in_ready;
    assign last     = (cnt == '0);

    // Phase, down-counter and registered bus strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            cs_n  <= 1'b1;
            wr_n  <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (load) begin
                        phase <= PH_SETUP;
                        cnt   <= SETUP_LD;
                        cs_n  <= 1'b0;
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        phase <= PH_STROBE;
                        cnt   <= LOW_LD;
                        wr_n  <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (last) begin
                        phase <= PH_HOLD;
                        cnt   <= HOLD_LD;
                        wr_n  <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last) begin
                        cs_n <= 1'b1;
                        done <= 1'b1;
                        cnt  <= REC_LD;
                        phase <= (REC_C > 0) ? PH_RECOV : PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_RECOV: begin
                    if (last) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Checker state: strobe low run length and cycles since the last falling edge.
    logic [CNT_W-1:0] low_run;
    logic [GAP_W-1:0] gap;
    logic             fell_seen;

    // Track strobe low width and falling-edge spacing for the properties below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run   <= '0;
            gap       <= '0;
            fell_seen <= 1'b0;
        end else begin
            low_run <= wr_n ? '0 : low_run + 1'b1;
            if ($fell(wr_n)) begin
                gap       <= GAP_W'(1);
                fell_seen <= 1'b1;
            end else if (gap != GAP_MAX) begin
                gap <= gap + 1'b1;
            end
        end
    end

    p_strobe_under_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !cs_n);

    p_low_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (low_run == LOW_LD + 1'b1));

    p_fall_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wr_n) && fell_seen) |-> (gap == GAP_MAX));

    p_busy_while_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !in_ready);

    p_done_at_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(cs_n));

    p_release_gives_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done);

endmodule

// File: rtl/pbus_write_master.sv
// Module pbus_write_master
// Write-only master for an 8-bit strobed parallel display bus. Takes a byte
// and a command/data flag on valid/ready and plays one write cycle that meets
// the bus minimum times, derived here as clock counts from CLK_PERIOD_NS.
// Assumes a single clock; bus outputs are registered; read strobe stays high.
module pbus_write_master
    import pbus_write_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 5,
    parameter int DATA_W        = 8,
    parameter int T_WR_LOW_NS   = 60,
    parameter int T_WR_HIGH_NS  = 60,
    parameter int T_CYCLE_NS    = 300,
    parameter int T_DSETUP_NS   = 40,
    parameter int T_DHOLD_NS    = 7,
    parameter int T_DCSETUP_NS  = 10,
    parameter int T_CSHOLD_NS   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_dc,
    input  logic [DATA_W-1:0] in_data,
    output logic              bus_cs_n,
    output logic              bus_wr_n,
    output logic              bus_rd_n,
    output logic              bus_dc,
    output logic [DATA_W-1:0] bus_data,
    output logic              done
);

    localparam int SETUP_C = ns_to_cycles(T_DCSETUP_NS, CLK_PERIOD_NS);
    localparam int LOW_C   = max_of(ns_to_cycles(T_WR_LOW_NS, CLK_PERIOD_NS),
                                    ns_to_cycles(T_DSETUP_NS, CLK_PERIOD_NS));
    localparam int HOLD_C  = max_of(ns_to_cycles(T_DHOLD_NS, CLK_PERIOD_NS),
                                    ns_to_cycles(T_CSHOLD_NS, CLK_PERIOD_NS));
    localparam int HIGH_C  = ns_to_cycles(T_WR_HIGH_NS, CLK_PERIOD_NS);
    localparam int CYC_C   = ns_to_cycles(T_CYCLE_NS, CLK_PERIOD_NS);
    localparam int BUSY_C  = max_of(max_of(CYC_C - 1, HIGH_C + LOW_C - 1),
                                    SETUP_C + LOW_C + HOLD_C);
    localparam int REC_C   = BUSY_C - (SETUP_C + LOW_C + HOLD_C);
    localparam int CNT_MAX = max_of(max_of(SETUP_C, LOW_C), max_of(HOLD_C, REC_C));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic load;

    pbus_phase_seq #(
        .SETUP_C (SETUP_C),
        .LOW_C   (LOW_C),
        .HOLD_C  (HOLD_C),
        .REC_C   (REC_C),
        .CYC_C   (CYC_C),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .load     (load),
        .cs_n     (bus_cs_n),
        .wr_n     (bus_wr_n),
        .done     (done)
    );

    pbus_hold_reg #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .dc_in   (in_dc),
        .data_in (in_data),
        .dc_q    (bus_dc),
        .data_q  (bus_data)
    );

    // Reads are never issued.
    assign bus_rd_n = 1'b1;

    p_bus_still_selected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_data) && $stable(bus_dc)));

    p_take_starts_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!bus_cs_n && bus_wr_n));

endmodule

// File: tb/pbus_write_master_test.sv
module pbus_write_master_test;

    localparam int P = 5;

    function automatic int cyc_of(input int ns);
        int c;
        c = (ns + P - 1) / P;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int EXP_S    = cyc_of(10);
    localparam int EXP_L    = mx(cyc_of(60), cyc_of(40));
    localparam int EXP_H    = mx(cyc_of(7), cyc_of(20));
    localparam int EXP_HI   = cyc_of(60);
    localparam int EXP_CYC  = cyc_of(300);
    localparam int EXP_BUSY = mx(mx(EXP_CYC - 1, EXP_HI + EXP_L - 1), EXP_S + EXP_L + EXP_H);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_dc = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, bus_cs_n, bus_wr_n, bus_rd_n, bus_dc, done;
    logic [7:0] bus_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [8:0] exp_q [$];
    bit finished = 1'b0;

    always #(P / 2.0) clk = ~clk;

    pbus_write_master #(.CLK_PERIOD_NS(P)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_dc(in_dc), .in_data(in_data), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
        .bus_rd_n(bus_rd_n), .bus_dc(bus_dc), .bus_data(bus_data), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Driver: offer one byte at a negedge, push expectation on acceptance,
    // scramble inputs while busy (R10) and measure the busy length (R2).
    task automatic send(input logic dc, input logic [7:0] b);
        int busy;
        in_valid = 1'b1;
        in_dc    = dc;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        exp_q.push_back({dc, b});
        @(posedge clk);
        busy = 0;
        @(negedge clk);
        while (!in_ready) begin
            busy++;
            in_data = ~in_data ^ 8'(busy);
            in_dc   = ~in_dc;
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(busy == EXP_BUSY, "R2 busy length", busy, EXP_BUSY);
    endtask

    // Monitor / scoreboard at negedges.
    int   cyc = 0, cs_fall = 0, last_fall = 0, last_rise = 0;
    bit   had_fall = 1'b0;
    logic prev_cs = 1'b1, prev_wr = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            prev_cs  <= 1'b1;
            prev_wr  <= 1'b1;
            had_fall <= 1'b0;
        end else begin
            if (prev_cs && !bus_cs_n) cs_fall = cyc;
            if (prev_wr && !bus_wr_n) begin
                chk(cyc - cs_fall == EXP_S, "R4 select-to-strobe", cyc - cs_fall, EXP_S);
                if (had_fall) begin
                    chk(cyc - last_fall >= EXP_CYC, "R6 cycle time", cyc - last_fall, EXP_CYC);
                    chk(cyc - last_rise >= EXP_HI, "R6 high time", cyc - last_rise, EXP_HI);
                end
                last_fall = cyc;
                had_fall  = 1'b1;
            end
            if (!prev_wr && bus_wr_n) begin
                logic [8:0] e;
                chk(cyc - last_fall == EXP_L, "R3 strobe low", cyc - last_fall, EXP_L);
                chk(bus_rd_n == 1'b1, "R8 read strobe", int'(bus_rd_n), 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected write", int'(bus_data), -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(bus_data == e[7:0], "R9 data byte", int'(bus_data), int'(e[7:0]));
                    chk(bus_dc == e[8], "R9 select level", int'(bus_dc), int'(e[8]));
                end
                last_rise = cyc;
            end
            if (!bus_wr_n && bus_cs_n)
                chk(1'b0, "R5 strobe without select", 1, 0);
            if (!prev_cs && bus_cs_n) begin
                chk(cyc - last_rise == EXP_H, "R5 select hold", cyc - last_rise, EXP_H);
                chk(done == 1'b1, "R7 done at release", int'(done), 1);
            end else if (done) begin
                chk(1'b0, "R7 stray done", 1, 0);
            end
            if (!bus_rd_n) chk(1'b0, "R8 read strobe low", 0, 1);
            prev_cs <= bus_cs_n;
            prev_wr <= bus_wr_n;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(bus_cs_n == 1'b1, "R1 cs_n in reset", int'(bus_cs_n), 1);
        chk(bus_wr_n == 1'b1, "R1 wr_n in reset", int'(bus_wr_n), 1);
        chk(bus_rd_n == 1'b1, "R1 rd_n in reset", int'(bus_rd_n), 1);
        chk(done == 1'b0, "R1 done in reset", int'(done), 0);
        chk(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        // Command stream with idle gaps
        send(1'b0, 8'hAE);
        repeat (5) @(negedge clk);
        send(1'b0, 8'hD5);
        send(1'b0, 8'h80);
        // Back-to-back data bytes, extreme values
        send(1'b1, 8'h00);
        send(1'b1, 8'hFF);
        send(1'b1, 8'hA5);
        send(1'b1, 8'h5A);
        repeat (17) @(negedge clk);
        // Alternating command and data
        for (int i = 0; i < 6; i++) begin
            send(i[0], 8'(8'h11 * i + 3));
            repeat (i) @(negedge clk);
        end
        repeat (EXP_BUSY + 10) @(negedge clk);
        // R2: every taken byte written, R1: idle again
        chk(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);
        chk(in_ready == 1'b1, "R2 ready when idle", int'(in_ready), 1);
        chk(bus_cs_n == 1'b1, "R5 deselected when idle", int'(bus_cs_n), 1);
        // R1: reset mid-write forces strobes inactive
        in_valid = 1'b1; in_dc = 1'b1; in_data = 8'h3C;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (EXP_S + 2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(bus_cs_n == 1'b1 && bus_wr_n == 1'b1, "R1 strobes after reset",
            int'({bus_cs_n, bus_wr_n}), 3);
        chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        finish_run();
    end

endmodule